// File: doc/BRIEF.md
# Background Built-In Test Status Sequencer

This block runs a continuous accuracy self-test over a set of output channels, one channel at a time. For each channel it takes the commanded angle and the angle measured back from the output, forms the shortest-way angular error, and decides whether the channel stayed within tolerance for its whole dwell. At the end of each dwell it writes the verdict for that channel into a small status register. A fault verdict latches: it stays set until the host reads the status register, and only then can a later update rewrite it. Marking a channel inactive therefore does not clear a fault that is already latched.

The block drives a fault-indicator output that is the OR of all status bits, and an interrupt request raised when a new fault appears while interrupts are enabled. A heartbeat register is reloaded with 55h at a fixed tick interval while testing runs, so the host can clear it and read it back later to confirm that the test is alive. All periods are counted in pulses of a single-cycle timebase tick input, so the same design serves real-time dwell lengths and short bench runs. The host reaches both registers through a plain register read/write port with a registered read result. All pins are control or status; the block has no streaming data path and so carries no valid/ready handshake.

Top module: `bg_bit_seq`

## Requirements
- R1: Register select 0 reads the status register: bit i (i = 0..NCH-1) is the fault bit of channel i (1 = accuracy failed, 0 = passed) and every higher bit of the read data is 0. After reset all status bits, the interrupt request, the fault output and the read data are 0. Host writes to select 0 have no effect.
- R2: While test_en_i is 1 the sequencer visits channels 0, 1, ..., NCH-1, 0, ... starting from channel 0 after reset, spending DWELL_TICKS tick pulses on each and producing one status update on the last tick of each dwell. While test_en_i is 0 no updates occur and the dwell restarts from its first tick when testing resumes.
- R3: A channel's verdict is fail when, in any clock cycle of its dwell, the absolute value of the modulo-2^16 difference between commanded and measured angle exceeds THRESH (default 36 LSB); an error of exactly THRESH passes, and the error is taken the short way around the wrap point.
- R4: An inactive channel (chan_active_i bit 0) receives 0 at its update instead of a test result, unless its bit is latched.
- R5: A status bit written to 1 is latched: later updates cannot change it, including updates for an inactive channel, until a status read.
- R6: A status read unlatches every bit, so the next update of each channel rewrites it. If a status read and an update fall in the same cycle, the read returns the old value and that update is dropped.
- R7: When irq_en_i is 1 and an update changes a status bit from 0 to 1, irq_o goes to 1 the next cycle and holds until a status read; with irq_en_i at 0 a new fault does not raise it.
- R8: fault_o is 1 exactly when at least one status bit is 1.
- R9: While test_en_i is 1 the verify register (select 1, bits 7:0) is loaded with 55h every HB_TICKS tick pulses; a host write to select 1 stores wdata bits 7:0 and wins over a heartbeat load in the same cycle; with test_en_i at 0 no heartbeat loads occur.
- R10: reg_rdata_o updates on the clock edge that samples reg_rd_i and holds otherwise; a verify read returns the register in bits 7:0 with bits 15:8 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle timebase pulse |
| test_en_i | input | 1 | Background test enable |
| irq_en_i | input | 1 | Interrupt enable |
| chan_active_i | input | NCH | Per-channel active flag |
| cmd_angle_i | input | NCH*16 | Commanded angles, channel i in bits 16i+15:16i |
| meas_angle_i | input | NCH*16 | Measured wrap-back angles, same packing |
| reg_sel_i | input | 1 | Register select: 0 status, 1 verify |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| fault_o | output | 1 | OR of all status bits |

## Verification
The assertions assume tick_i is a single-cycle pulse, that reg_rd_i and reg_wr_i are never both high, and that angles are held between clock edges; the bench drives every input at the falling edge and only raises one strobe at a time. They also assume the channel count is at least two for the channel-advance check. The stimulus times reads to land exactly on an update slot and heartbeat writes exactly on a heartbeat load, using the bench's own tick counting, so the collision rules are hit on purpose rather than by chance.

// File: rtl/bg_bit_pkg.sv
package bg_bit_pkg;
  localparam int ANGLE_W = 16;
  localparam int REG_W   = 16;
  localparam int VER_W   = 8;
  localparam logic [VER_W-1:0] HB_PATTERN = 8'h55;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_VERIFY = 1'b1} reg_sel_e;
endpackage

// File: rtl/bg_bit_angle_err.sv
module bg_bit_angle_err #(
  parameter int AW     = 16,
  parameter int THRESH = 36
) (
  input  logic [AW-1:0] cmd_i,
  input  logic [AW-1:0] meas_i,
  output logic          over_o
);
  localparam logic [AW-1:0] TH_V = AW'(THRESH);
  logic [AW-1:0] diff, mag;
  assign diff   = cmd_i - meas_i;
  assign mag    = diff[AW-1] ? (~diff + 1'b1) : diff;
  assign over_o = (mag > TH_V);
endmodule

// File: rtl/bg_bit_dwell_seq.sv
module bg_bit_dwell_seq #(
  parameter int NCH         = 2,
  parameter int DWELL_TICKS = 180,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CNTW = $clog2(DWELL_TICKS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           en_i,
  input  logic [NCH-1:0] active_i,
  input  logic [NCH-1:0] over_i,
  output logic           upd_o,
  output logic [CW-1:0]  upd_ch_o,
  output logic           upd_res_o
);
  localparam logic [CNTW-1:0] LAST_CNT = CNTW'(DWELL_TICKS - 1);
  localparam logic [CW-1:0]   LAST_CH  = CW'(NCH - 1);

  logic [CNTW-1:0] cnt_q;
  logic [CW-1:0]   ch_q;
  logic            acc_q;
  logic            acc_now;

  assign acc_now   = acc_q | over_i[ch_q];
  assign upd_o     = en_i & tick_i & (cnt_q == LAST_CNT);
  assign upd_ch_o  = ch_q;
  assign upd_res_o = active_i[ch_q] & acc_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ch_q  <= '0;
      acc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (upd_o) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
      ch_q  <= (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
    end else begin
      acc_q <= acc_now;
      if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the channel pointer never leaves the channel range
  p_ch_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ch_q <= LAST_CH);
  // R2: while disabled, the next enabled dwell starts from its first tick
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0) && !acc_q);
  generate
    if (NCH > 1) begin : g_adv
      // R2: every update moves the pointer to another channel
      p_chan_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> (ch_q != $past(ch_q)));
    end
  endgenerate
endmodule

// File: rtl/bg_bit_stat_latch.sv
module bg_bit_stat_latch #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_i,
  input  logic [CW-1:0]  upd_ch_i,
  input  logic           upd_res_i,
  input  logic           rd_stat_i,
  input  logic           irq_en_i,
  output logic [NCH-1:0] stat_o,
  output logic           irq_o
);
  logic [NCH-1:0] stat_q, lock_q;
  logic           irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      lock_q <= '0;
      irq_q  <= 1'b0;
    end else if (rd_stat_i) begin
      lock_q <= '0;
      irq_q  <= 1'b0;
    end else if (upd_i && !lock_q[upd_ch_i]) begin
      stat_q[upd_ch_i] <= upd_res_i;
      lock_q[upd_ch_i] <= upd_res_i;
      if (upd_res_i && !stat_q[upd_ch_i] && irq_en_i) irq_q <= 1'b1;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  // R5: a latched bit is always a set bit
  p_lock_is_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & ~stat_q) == '0);
  // R5: latched bits survive every cycle without a status read
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat_i && (lock_q != '0)) |=> ((stat_q & $past(lock_q)) == $past(lock_q)));
  // R6: an update colliding with a status read is dropped
  p_slot_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_i && upd_i) |=> (stat_q == $past(stat_q)));
  // R7: a request only appears from an enabled update
  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(irq_en_i) && $past(upd_i) && $past(upd_res_i)));
endmodule

// File: rtl/bg_bit_heartbeat.sv
module bg_bit_heartbeat #(
  parameter int HB_TICKS = 1000,
  parameter int VW       = 8,
  parameter logic [VW-1:0] PATTERN = 8'h55,
  localparam int HBW = $clog2(HB_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [VW-1:0] wdata_i,
  output logic [VW-1:0] ver_o
);
  localparam logic [HBW-1:0] LAST_HB = HBW'(HB_TICKS - 1);
  logic [HBW-1:0] hb_q;
  logic [VW-1:0]  ver_q;
  logic           pulse;

  assign pulse = en_i & tick_i & (hb_q == LAST_HB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_q  <= '0;
      ver_q <= '0;
    end else begin
      if (!en_i)       hb_q <= '0;
      else if (pulse)  hb_q <= '0;
      else if (tick_i) hb_q <= hb_q + 1'b1;
      if (wr_i)        ver_q <= wdata_i;
      else if (pulse)  ver_q <= PATTERN;
    end
  end

  assign ver_o = ver_q;

  // R9: a heartbeat load without a host write leaves the pattern
  p_hb_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !wr_i) |=> (ver_q == PATTERN));
  // R9: a host write always lands, even on a heartbeat slot
  p_host_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (ver_q == $past(wdata_i)));
endmodule

// File: rtl/bg_bit_seq.sv
module bg_bit_seq
  import bg_bit_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int THRESH      = 36,
  parameter int DWELL_TICKS = 180,
  parameter int HB_TICKS    = 1000,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   test_en_i,
  input  logic                   irq_en_i,
  input  logic [NCH-1:0]         chan_active_i,
  input  logic [NCH*ANGLE_W-1:0] cmd_angle_i,
  input  logic [NCH*ANGLE_W-1:0] meas_angle_i,
  input  logic                   reg_sel_i,
  input  logic                   reg_rd_i,
  input  logic                   reg_wr_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [REG_W-1:0]       reg_rdata_o,
  output logic                   irq_o,
  output logic                   fault_o
);
  logic [NCH-1:0] over;
  logic           upd, upd_res;
  logic [CW-1:0]  upd_ch;
  logic [NCH-1:0] stat;
  logic [VER_W-1:0] ver;
  logic           rd_stat, wr_ver;
  logic [REG_W-1:0] rdata_q;

  assign rd_stat = reg_rd_i & (reg_sel_e'(reg_sel_i) == SEL_STATUS);
  assign wr_ver  = reg_wr_i & (reg_sel_e'(reg_sel_i) == SEL_VERIFY);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_err
      bg_bit_angle_err #(.AW(ANGLE_W), .THRESH(THRESH)) u_err (
        .cmd_i (cmd_angle_i[i*ANGLE_W +: ANGLE_W]),
        .meas_i(meas_angle_i[i*ANGLE_W +: ANGLE_W]),
        .over_o(over[i])
      );
    end
  endgenerate

  bg_bit_dwell_seq #(.NCH(NCH), .DWELL_TICKS(DWELL_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(test_en_i),
    .active_i(chan_active_i), .over_i(over),
    .upd_o(upd), .upd_ch_o(upd_ch), .upd_res_o(upd_res)
  );

  bg_bit_stat_latch #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .upd_ch_i(upd_ch),
    .upd_res_i(upd_res), .rd_stat_i(rd_stat), .irq_en_i(irq_en_i),
    .stat_o(stat), .irq_o(irq_o)
  );

  bg_bit_heartbeat #(.HB_TICKS(HB_TICKS), .VW(VER_W), .PATTERN(HB_PATTERN)) u_hb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(test_en_i),
    .wr_i(wr_ver), .wdata_i(reg_wdata_i[VER_W-1:0]), .ver_o(ver)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd_i)
      rdata_q <= rd_stat ? {{(REG_W-NCH){1'b0}}, stat}
                         : {{(REG_W-VER_W){1'b0}}, ver};
  end

  assign reg_rdata_o = rdata_q;
  assign fault_o     = |stat;

  // R1: a status read never shows bits above the channel field
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stat) |-> (reg_rdata_o[REG_W-1:NCH] == '0));
  // R10: read data only moves on a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

// File: tb/bg_bit_seq_tb.sv
module bg_bit_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int TH  = 36;
  localparam int DW  = 4;
  localparam int HB  = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, ten = 1'b0, ien = 1'b1;
  logic [NCH-1:0] act = '1;
  logic [NCH*16-1:0] cmd = '0, meas = '0;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq, flt;

  always #(CLK_PERIOD/2) clk = ~clk;

  bg_bit_seq #(.NCH(NCH), .THRESH(TH), .DWELL_TICKS(DW), .HB_TICKS(HB)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .test_en_i(ten), .irq_en_i(ien),
    .chan_active_i(act), .cmd_angle_i(cmd), .meas_angle_i(meas),
    .reg_sel_i(sel), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .fault_o(flt)
  );

  typedef struct {
    logic        irq;
    logic        flt;
    logic [15:0] rd;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  string tag = "R1";

  // reference state kept from the requirements
  int m_cnt = 0, m_ch = 0, m_hb = 0;
  bit m_acc = 0, m_irq = 0;
  bit [NCH-1:0] m_stat = '0, m_lock = '0;
  bit [7:0] m_ver = '0;
  bit [15:0] m_rd = '0;

  task automatic chk(string t, string what, logic [15:0] a, logic [15:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, a, e);
    end
  endtask

  function automatic bit too_far(logic [15:0] c, logic [15:0] m);
    int d;
    d = int'(c) - int'(m);
    if (d < 0) d = -d;
    if (d > 32768) d = 65536 - d;
    return d > TH;
  endfunction

  task automatic cycle();
    bit upd, res, rds, pulse;
    int uc;
    exp_t e;
    upd = 0; res = 0; uc = m_ch;
    if (rd) m_rd = sel ? {8'h00, m_ver} : {14'b0, m_stat};
    if (!ten) begin
      m_cnt = 0; m_acc = 0;
    end else begin
      bit f;
      f = too_far(cmd[uc*16 +: 16], meas[uc*16 +: 16]);
      upd = tick && (m_cnt == DW-1);
      res = act[uc] && (m_acc || f);
      if (upd) begin m_cnt = 0; m_acc = 0; m_ch = (m_ch + 1) % NCH; end
      else begin m_acc = m_acc || f; if (tick) m_cnt++; end
    end
    rds = rd && !sel;
    if (rds) begin m_lock = '0; m_irq = 0; end
    else if (upd && !m_lock[uc]) begin
      if (res && !m_stat[uc] && ien) m_irq = 1;
      m_stat[uc] = res; m_lock[uc] = res;
    end
    pulse = ten && tick && (m_hb == HB-1);
    if (!ten || pulse) m_hb = 0; else if (tick) m_hb++;
    if (wr && sel) m_ver = wdata[7:0];
    else if (pulse) m_ver = 8'h55;
    e.irq = m_irq; e.flt = |m_stat; e.rd = m_rd; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: pops the expected item for each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "rdata(R10)", rdata, e.rd);
        chk(e.tag, "irq(R7)", {15'b0, irq}, {15'b0, e.irq});
        chk(e.tag, "fault(R8)", {15'b0, flt}, {15'b0, e.flt});
      end
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic rd_reg(bit s);
    sel = s; rd = 1'b1; cycle(); rd = 1'b0; cycle();
  endtask

  task automatic wr_ver(logic [7:0] v);
    sel = 1'b1; wr = 1'b1; wdata = {8'hA5, v}; cycle(); wr = 1'b0;
  endtask

  task automatic set_ang(int ch, logic [15:0] c, logic [15:0] m);
    cmd[ch*16 +: 16] = c; meas[ch*16 +: 16] = m;
  endtask

  task automatic wait_slot(int ch);
    while (!(ten && tick && m_cnt == DW-1 && m_ch == ch)) cycle();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_ang(0, 16'd1000, 16'd1000); set_ang(1, 16'd1000, 16'd1000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "rdata", rdata, 16'h0000);
    chk("R1", "irq", {15'b0, irq}, 16'h0);
    chk("R1", "fault", {15'b0, flt}, 16'h0);
    tick = 1'b1;

    tag = "R2"; ten = 1'b1; run(17); rd_reg(0);
    // R3: exactly THRESH passes, short-way wrap of 21 passes
    tag = "R3";
    set_ang(0, 16'd1000, 16'd1036); set_ang(1, 16'h0005, 16'hFFF0);
    run(17); rd_reg(0);
    // R3/R7: wrap error of 48 fails on channel 1
    tag = "R7"; set_ang(1, 16'h0010, 16'hFFE0); run(9);
    // R5: inactive does not clear a latched fault
    tag = "R5"; act = 2'b01; set_ang(1, 16'd7, 16'd7); run(17); rd_reg(0);
    // R4/R6: after the read the inactive channel is rewritten to 0
    tag = "R4"; run(17); rd_reg(0);
    // R1: status writes are ignored
    tag = "R1"; sel = 1'b0; wr = 1'b1; wdata = 16'hFFFF; cycle(); wr = 1'b0; rd_reg(0);
    // R6: read colliding with an update slot
    tag = "R6"; act = 2'b11; set_ang(0, 16'd1000, 16'd2000); run(9);
    set_ang(0, 16'd1000, 16'd1000); wait_slot(0);
    sel = 1'b0; rd = 1'b1; cycle(); rd = 1'b0; cycle(); rd_reg(0);
    run(9); rd_reg(0);
    // R3: a one-cycle glitch inside the dwell fails the channel
    tag = "R3"; run(1); set_ang(0, 16'd1000, 16'd1100); cycle();
    set_ang(0, 16'd1000, 16'd1000); run(9); rd_reg(0); run(9); rd_reg(0);
    // R7: interrupts disabled
    tag = "R7"; ien = 1'b0; set_ang(1, 16'd50, 16'd0); run(9); rd_reg(0);
    set_ang(1, 16'd50, 16'd50); ien = 1'b1; run(9); rd_reg(0);
    // R2: disabled sequencer makes no updates
    tag = "R2"; ten = 1'b0; set_ang(0, 16'd0, 16'd400); run(21); rd_reg(0);
    set_ang(0, 16'd0, 16'd0); ten = 1'b1; tick = 1'b0; run(5); tick = 1'b1; run(3); rd_reg(0);
    // R9: heartbeat
    tag = "R9"; wr_ver(8'h00); rd_reg(1); run(14); rd_reg(1);
    wr_ver(8'h00);
    while (!(ten && tick && m_hb == HB-1)) cycle();
    wr_ver(8'h12); rd_reg(1);
    ten = 1'b0; wr_ver(8'h00); run(30); rd_reg(1);
    tag = "R10"; ten = 1'b1; run(15); rd_reg(1); run(3);
    @(negedge clk); @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule